// File: doc/BRIEF.md
# PS/2 Device-to-Host Receiver with Pulse-Count Interrupts

This block is the receive half of a PS/2 host controller. It brings the device's open-collector clock and data lines into the system clock domain and finds each falling clock edge. On every falling edge it shifts one bit into an eleven-bit frame register. A reloadable down-counter counts those edges and raises an interrupt when it runs out, so software hears from the block only at chosen points in a frame.

Two counting schemes are available. In single mode the counter first loads 9, which covers the start bit and the eight data bits. After that it loads 11, which covers the parity and stop bits of the current frame and the start and data bits of the next. Each byte then costs one interrupt. In checking mode the counter alternates between 8 and 3. The first interrupt arrives after the start bit and seven data bits, and the second after the last data bit, parity and stop. At the second interrupt the byte is delivered and the whole frame is checked. A framing error makes the block hold the clock line low for a while and then re-arm, so it resynchronizes to the next frame. The host can also inhibit the device by holding the clock line low. A control write selects the mode and re-arms the counter, and the live counter value is always visible.

Top module: `ps2_pulse_rx`

## Requirements
- R1: A frame is eleven bits (start, eight data bits least significant first, odd parity, stop), each taken on one falling edge of the synchronized clock line. Every falling edge advances the counter by exactly one, and the byte reported on `rx_byte` has data bit 0 as its LSB.
- R2: In single mode (`ctl_check`=0 at the last control write, and after reset) the counter starts at 9. The 9th falling edge raises `irq`, updates `rx_byte` and reloads 11. Each later byte raises `irq` at its 8th data bit, and the counter reads 9 on an idle line after every complete frame.
- R3: In checking mode (`ctl_check`=1) the counter starts at 8. The 8th falling edge raises `irq` and reloads 3. The 11th raises `irq` again, updates `rx_byte` and reloads 8.
- R4: In checking mode a frame fails if the start bit is 1 (checked at the first interrupt), or if the data bits plus parity hold an even number of ones, or if the stop bit is 0 (checked at the second). A failure sets `frame_err`, which stays set until a control write.
- R5: Single mode performs no frame checks. A frame with wrong parity still delivers its byte and leaves `frame_err` at 0.
- R6: `irq` stays at 1 until `irq_ack` is pulsed, and an acknowledge clears it on the following cycle.
- R7: While `cmd_inhibit` is 1, `ps2_clk_hold` is 1, the counter is held at its initial load (9 in single mode, 8 in checking mode) and clock edges are ignored. After release the next whole frame is received correctly.
- R8: A framing error drives `ps2_clk_hold` to 1 for HOLD_CYC cycles and then releases it. The counter is back at its initial load afterwards.
- R9: A control write (`ctl_we`=1) latches the mode from `ctl_check`, loads the counter with that mode's initial value, and clears `irq`, `frame_err` and any automatic hold.
- R10: `cnt_val` shows the falling edges left before the next interrupt at every cycle. For example, it reads 3 after five bits of a frame in checking mode.
- R11: After reset `cnt_val` is 9, `irq`, `frame_err` and `ps2_clk_hold` are 0, and `rx_byte` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_in | input | 1 | PS/2 clock line level (asynchronous) |
| ps2_dat_in | input | 1 | PS/2 data line level (asynchronous) |
| ps2_clk_hold | output | 1 | 1 = pull the clock line low; 0 = release it (never drives high) |
| ctl_we | input | 1 | Control write strobe: latch mode, re-arm counter, clear flags |
| ctl_check | input | 1 | Mode written by `ctl_we`: 0 single, 1 checking |
| irq_ack | input | 1 | Clears `irq` (byte read) |
| cmd_inhibit | input | 1 | Host request to hold the clock line low |
| irq | output | 1 | Interrupt request, sticky |
| rx_byte | output | 8 | Most recently delivered data byte |
| frame_err | output | 1 | Sticky framing or parity error |
| cnt_val | output | 4 | Live pulse counter value |

## Verification
The embedded properties check these rules on every cycle: one falling edge gives a one-cycle shift event, each shift enters the newest bit at the top of the frame register, and the counter steps down by one per edge. They also check that an expiry always raises the interrupt, that `irq` and `frame_err` stay set until they are cleared, and that any clock hold leaves the counter at its initial load. Only the bench scenarios show the rest: the correct byte for all 256 values in both modes, the idle counter values, the split interrupt in checking mode, parity, stop and start faults, the timed release after an error, and resynchronization after a host inhibit.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;
    localparam int CNT_W      = 4;
    localparam int FRAME_BITS = 11;

    // counter load values
    localparam logic [CNT_W-1:0] LD_ONE_FIRST = 4'd9;
    localparam logic [CNT_W-1:0] LD_ONE_NEXT  = 4'd11;
    localparam logic [CNT_W-1:0] LD_CHK_HEAD  = 4'd8;
    localparam logic [CNT_W-1:0] LD_CHK_TAIL  = 4'd3;

    // bit positions inside the frame register after an expiry
    localparam int HEAD_START_POS = FRAME_BITS - int'(LD_CHK_HEAD);
    localparam int ONE_DATA_LSB   = FRAME_BITS - int'(LD_ONE_FIRST) + 1;

    typedef enum logic {PH_HEAD, PH_TAIL} phase_t;

    // frame as it sits in the shift register after eleven shifts
    typedef struct packed {
        logic       stop;
        logic       par;
        logic [7:0] data;
        logic       start;
    } frame_t;

    function automatic logic odd_ok(input logic [8:0] bits);
        return ^bits;
    endfunction

    function automatic logic [CNT_W-1:0] init_load(input logic chk);
        return chk ? LD_CHK_HEAD : LD_ONE_FIRST;
    endfunction
endpackage

// File: rtl/ps2rx_sync.sv
module ps2rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_clk,
    input  logic line_dat,
    output logic fall,
    output logic dat_s
);
    logic [STAGES-1:0] clk_q;
    logic [STAGES-1:0] dat_q;
    logic              clk_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q    <= '1;
            dat_q    <= '1;
            clk_last <= 1'b1;
        end else begin
            clk_q    <= {clk_q[STAGES-2:0], line_clk};
            dat_q    <= {dat_q[STAGES-2:0], line_dat};
            clk_last <= clk_q[STAGES-1];
        end
    end

    assign fall  = clk_last & ~clk_q[STAGES-1];
    assign dat_s = dat_q[STAGES-1];

    // R1
    single_fall_chk: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);
endmodule

// File: rtl/ps2rx_shifter.sv
module ps2rx_shifter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] sr_next
);
    logic [W-1:0] sr;

    assign sr_next = {din, sr[W-1:1]};

    always_ff @(posedge clk) begin
        if (rst)           sr <= '0;
        else if (shift_en) sr <= sr_next;
    end

    // R1
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> sr[W-1] == $past(din));
endmodule

// File: rtl/ps2rx_pulse_ctr.sv
module ps2rx_pulse_ctr
    import ps2rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             at_last
);
    always_ff @(posedge clk) begin
        if (rst)                      cnt <= LD_ONE_FIRST;
        else if (load)                cnt <= load_val;
        else if (dec && cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign at_last = (cnt == CNT_W'(1));

    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/ps2_pulse_rx.sv
module ps2_pulse_rx
    import ps2rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ps2_clk_in,
    input  logic             ps2_dat_in,
    output logic             ps2_clk_hold,
    input  logic             ctl_we,
    input  logic             ctl_check,
    input  logic             irq_ack,
    input  logic             cmd_inhibit,
    output logic             irq,
    output logic [7:0]       rx_byte,
    output logic             frame_err,
    output logic [CNT_W-1:0] cnt_val
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    logic                  fall, dat_s, fall_ok, block, expire, at_last, ld, chk_bad;
    logic [FRAME_BITS-1:0] sr_next;
    logic [CNT_W-1:0]      ld_val;
    logic                  chk_mode;
    phase_t                phase;
    logic [HW-1:0]         hold_cnt;
    logic [2:0]            hold_hist;
    frame_t                tail_f;

    ps2rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .line_clk(ps2_clk_in), .line_dat(ps2_dat_in),
        .fall(fall), .dat_s(dat_s)
    );

    ps2rx_shifter #(.W(FRAME_BITS)) u_shift (
        .clk(clk), .rst(rst), .shift_en(fall_ok), .din(dat_s), .sr_next(sr_next)
    );

    ps2rx_pulse_ctr u_ctr (
        .clk(clk), .rst(rst), .load(ld), .load_val(ld_val), .dec(fall_ok),
        .cnt(cnt_val), .at_last(at_last)
    );

    assign ps2_clk_hold = cmd_inhibit | (hold_cnt != '0);
    // edges caused by our own hold are masked for a few cycles after it
    assign block   = ps2_clk_hold | (|hold_hist);
    assign fall_ok = fall & ~block;
    assign expire  = fall_ok & at_last & ~ctl_we;
    assign ld      = ctl_we | block | expire;
    assign tail_f  = frame_t'(sr_next);

    always_comb begin
        if (ctl_we || block)   ld_val = init_load(ctl_we ? ctl_check : chk_mode);
        else if (chk_mode)     ld_val = (phase == PH_HEAD) ? LD_CHK_TAIL : LD_CHK_HEAD;
        else                   ld_val = LD_ONE_NEXT;

        chk_bad = 1'b0;
        if (expire && chk_mode) begin
            if (phase == PH_HEAD) chk_bad = sr_next[HEAD_START_POS];
            else chk_bad = tail_f.start | ~tail_f.stop | ~odd_ok({tail_f.par, tail_f.data});
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_mode  <= 1'b0;
            phase     <= PH_HEAD;
            irq       <= 1'b0;
            frame_err <= 1'b0;
            rx_byte   <= '0;
            hold_cnt  <= '0;
            hold_hist <= '0;
        end else begin
            hold_hist <= {hold_hist[1:0], ps2_clk_hold};
            if (ctl_we) begin
                chk_mode  <= ctl_check;
                phase     <= PH_HEAD;
                irq       <= 1'b0;
                frame_err <= 1'b0;
                hold_cnt  <= '0;
            end else begin
                if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
                if (block) phase <= PH_HEAD;
                if (expire) begin
                    irq <= 1'b1;
                    if (chk_mode) begin
                        phase <= (phase == PH_HEAD) ? PH_TAIL : PH_HEAD;
                        if (phase == PH_TAIL) rx_byte <= tail_f.data;
                    end else begin
                        phase   <= PH_TAIL;
                        rx_byte <= sr_next[ONE_DATA_LSB+7:ONE_DATA_LSB];
                    end
                end else if (irq_ack) begin
                    irq <= 1'b0;
                end
                if (chk_bad) begin
                    frame_err <= 1'b1;
                    hold_cnt  <= HW'(HOLD_CYC);
                end
            end
        end
    end

    // R2
    expire_irq_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> irq);
    // R6
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_ack && !ctl_we) |=> irq);
    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_err && !ctl_we) |=> frame_err);
    // R7
    hold_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (ps2_clk_hold && !ctl_we) |=> cnt_val == init_load(chk_mode));
endmodule

// File: tb/sim_ps2_pulse_rx.sv
`timescale 1ns/1ps
module sim_ps2_pulse_rx;
    localparam int HALF = 6;
    localparam int HOLD = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dev_clk = 1'b1, dev_dat = 1'b1;
    logic ctl_we = 1'b0, ctl_check = 1'b0, irq_ack = 1'b0, cmd_inhibit = 1'b0;
    logic ps2_clk_hold, irq, frame_err;
    logic [7:0] rx_byte;
    logic [3:0] cnt_val;
    int tests = 0, fails = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ps2_pulse_rx #(.SYNC_STAGES(2), .HOLD_CYC(HOLD)) u0 (
        .clk(clk), .rst(rst),
        .ps2_clk_in(dev_clk & ~ps2_clk_hold), .ps2_dat_in(dev_dat),
        .ps2_clk_hold(ps2_clk_hold), .ctl_we(ctl_we), .ctl_check(ctl_check),
        .irq_ack(irq_ack), .cmd_inhibit(cmd_inhibit), .irq(irq),
        .rx_byte(rx_byte), .frame_err(frame_err), .cnt_val(cnt_val)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [10:0] mk_frame(input logic [7:0] b, input bit bad_par,
                                             input bit bad_stop, input bit bad_start);
        logic par;
        par = ~(^b) ^ bad_par;
        return {~bad_stop, par, b, bad_start};
    endfunction

    task automatic send_bits(input logic [10:0] f, input int lo, input int hi);
        for (int i = lo; i <= hi; i++) begin
            dev_dat = f[i];
            wait_cyc(HALF);
            dev_clk = 1'b0;
            wait_cyc(HALF);
            dev_clk = 1'b1;
        end
    endtask

    task automatic send_frame(input logic [10:0] f);
        send_bits(f, 0, 10);
        dev_dat = 1'b1;
        wait_cyc(2 * HALF);
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        wait_cyc(1);
        irq_ack = 1'b0;
    endtask

    task automatic ctl_write(input logic chk);
        ctl_check = chk;
        ctl_we = 1'b1;
        wait_cyc(1);
        ctl_we = 1'b0;
    endtask

    initial begin
        wait (cyc > 190000);
        chk(1'b0, "watchdog", cyc, 190000);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(1);
        // R11 reset state
        chk(cnt_val == 4'd9, "R11 cnt", cnt_val, 9);
        chk(!irq && !frame_err && !ps2_clk_hold, "R11 flags", {irq, frame_err, ps2_clk_hold}, 0);
        chk(rx_byte == 8'h00, "R11 byte", rx_byte, 0);

        // R1 R2 single mode sweep over all byte values
        for (int b = 0; b < 256; b++) begin
            send_frame(mk_frame(8'(b), 1'b0, 1'b0, 1'b0));
            chk(irq == 1'b1, "R2 irq", irq, 1);
            chk(rx_byte == 8'(b), "R1 byte single", rx_byte, b);
            chk(cnt_val == 4'd9, "R2 idle cnt", cnt_val, 9);
            if (b == 3) begin
                wait_cyc(5);
                chk(irq == 1'b1, "R6 irq held", irq, 1);
            end
            ack();
            chk(irq == 1'b0, "R6 ack", irq, 0);
        end

        // R5 single mode ignores parity faults
        send_frame(mk_frame(8'hC3, 1'b1, 1'b0, 1'b0));
        chk(rx_byte == 8'hC3, "R5 byte", rx_byte, 8'hC3);
        chk(frame_err == 1'b0 && ps2_clk_hold == 1'b0, "R5 no err", frame_err, 0);
        ack();

        // R9 switch to checking mode
        ctl_write(1'b1);
        chk(cnt_val == 4'd8, "R9 reload", cnt_val, 8);
        chk(irq == 1'b0, "R9 irq clr", irq, 0);

        // R3 split frame in checking mode
        send_bits(mk_frame(8'hA5, 1'b0, 1'b0, 1'b0), 0, 7);
        chk(irq == 1'b1, "R3 head irq", irq, 1);
        chk(cnt_val == 4'd3, "R3 tail load", cnt_val, 3);
        ack();
        send_bits(mk_frame(8'hA5, 1'b0, 1'b0, 1'b0), 8, 10);
        wait_cyc(2 * HALF);
        chk(irq == 1'b1, "R3 tail irq", irq, 1);
        chk(rx_byte == 8'hA5, "R3 byte", rx_byte, 8'hA5);
        chk(cnt_val == 4'd8, "R3 rearm", cnt_val, 8);
        ack();

        // R1 R3 checking mode sweep
        for (int b = 0; b < 256; b++) begin
            send_frame(mk_frame(8'(b), 1'b0, 1'b0, 1'b0));
            chk(rx_byte == 8'(b), "R3 byte chk", rx_byte, b);
            chk(cnt_val == 4'd8 && frame_err == 1'b0, "R3 idle", cnt_val, 8);
            ack();
        end

        // R4 R8 parity fault
        send_frame(mk_frame(8'h3C, 1'b1, 1'b0, 1'b0));
        chk(frame_err == 1'b1, "R4 parity", frame_err, 1);
        chk(ps2_clk_hold == 1'b1, "R8 hold on", ps2_clk_hold, 1);
        wait_cyc(HOLD + 10);
        chk(ps2_clk_hold == 1'b0, "R8 release", ps2_clk_hold, 0);
        chk(cnt_val == 4'd8, "R8 cnt", cnt_val, 8);
        ack();
        send_frame(mk_frame(8'h81, 1'b0, 1'b0, 1'b0));
        chk(rx_byte == 8'h81, "R8 resync byte", rx_byte, 8'h81);
        chk(frame_err == 1'b1, "R4 sticky", frame_err, 1);
        ctl_write(1'b1);
        chk(frame_err == 1'b0, "R9 err clr", frame_err, 0);

        // R4 stop fault
        send_frame(mk_frame(8'h11, 1'b0, 1'b1, 1'b0));
        chk(frame_err == 1'b1, "R4 stop", frame_err, 1);
        wait_cyc(HOLD + 10);
        ctl_write(1'b1);

        // R4 start fault seen at the first interrupt
        send_bits(mk_frame(8'h77, 1'b0, 1'b0, 1'b1), 0, 7);
        dev_dat = 1'b1;
        wait_cyc(2);
        chk(frame_err == 1'b1 && ps2_clk_hold == 1'b1, "R4 start", {frame_err, ps2_clk_hold}, 3);
        wait_cyc(HOLD + 10);
        chk(cnt_val == 4'd8, "R8 cnt start", cnt_val, 8);
        ctl_write(1'b1);

        // R10 R7 progress and host inhibit
        send_bits(mk_frame(8'hE7, 1'b0, 1'b0, 1'b0), 0, 4);
        chk(cnt_val == 4'd3, "R10 progress", cnt_val, 3);
        cmd_inhibit = 1'b1;
        wait_cyc(10);
        chk(ps2_clk_hold == 1'b1, "R7 hold", ps2_clk_hold, 1);
        chk(cnt_val == 4'd8, "R7 reload", cnt_val, 8);
        send_bits(mk_frame(8'hE7, 1'b0, 1'b0, 1'b0), 0, 2);
        chk(cnt_val == 4'd8, "R7 ignored", cnt_val, 8);
        cmd_inhibit = 1'b0;
        dev_dat = 1'b1;
        wait_cyc(10);
        send_frame(mk_frame(8'h5A, 1'b0, 1'b0, 1'b0));
        chk(rx_byte == 8'h5A, "R7 resync byte", rx_byte, 8'h5A);
        chk(cnt_val == 4'd8 && frame_err == 1'b0, "R7 resync state", cnt_val, 8);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule